// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block adds or subtracts two operands held in sign-magnitude form. Each operand is a sign bit and an unsigned magnitude of `W` bits. A single control bit chooses between addition and subtraction. The block first works out the effective sign of the second operand. From the two signs it decides whether the magnitudes are added or subtracted.

Magnitude subtraction is done as A + not(B) + 1. The carry-out of that sum tells whether A is at least B. When the carry-out is clear, the raw result is the two's complement of the true difference, so it is complemented back and the sign is flipped. When magnitudes are added, the carry-out of the sum is reported as an overflow flag.

The result is registered. It appears one clock after the input is marked valid, and it holds while no new input arrives.

Top module: `sm_addsub`

## Requirements
- R1: When `op_sub` is 1, the sign of B is inverted and the inverted sign is used by every rule below; when `op_sub` is 0, B's sign is used as given.
- R2: When A's sign equals B's effective sign, `res_mag` is (a_mag + b_mag) mod 2^W and `res_sign` equals `a_sign`, including a negative zero from adding two negative zeros.
- R3: When the magnitudes are added, `ovf` is 1 exactly when a_mag + b_mag is at least 2^W.
- R4: `ovf` is 0 whenever the effective signs differ.
- R5: With differing effective signs and a_mag > b_mag, `res_mag` is a_mag - b_mag and `res_sign` is `a_sign`.
- R6: With differing effective signs and a_mag < b_mag, `res_mag` is b_mag - a_mag and `res_sign` is the inverse of `a_sign`.
- R7: With differing effective signs and a_mag == b_mag, the result is positive zero: `res_sign` is 0 and `res_mag` is 0.
- R8: `out_vld` and the result outputs update one clock after a cycle with `in_vld` high. While `rst_n` is low, `out_vld`, `res_sign`, `res_mag` and `ovf` are all 0.
- R9: After a cycle with `in_vld` low, `res_sign`, `res_mag` and `ovf` keep their values and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_mag | input | W | Magnitude of A |
| b_sign | input | 1 | Sign of B (1 = negative) |
| b_mag | input | W | Magnitude of B |
| op_sub | input | 1 | 0 = A + B, 1 = A - B |
| out_vld | output | 1 | Result registered from a valid input |
| res_sign | output | 1 | Sign of the result |
| res_mag | output | W | Magnitude of the result |
| ovf | output | 1 | Magnitude sum carried out |

## Verification
The assertions are evaluated on every clock cycle. They cover:
- the one-cycle latency of `out_vld`;
- holding the outputs on idle cycles;
- the overflow flag staying clear when the magnitudes are subtracted;
- the sign rules for equal signs and for differing signs with a larger or a smaller A;
- the positive zero produced by a cancelling difference.

The exact magnitudes are checked only by the bench. It applies every combination of the two signs, the mode and all magnitudes of a narrow instance, and compares each result with an integer model. The bench scenarios are also the only evidence for:
- the wrapped magnitude on overflow;
- the negative zero produced by adding two negative zeros;
- the reset values.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

   // Which magnitude operation the sign logic selected
   typedef enum logic {
      PATH_SUM  = 1'b0,
      PATH_DIFF = 1'b1
   } mag_path_e;

   // Adder implementation variants
   localparam int ADD_RIPPLE = 0;
   localparam int ADD_BEHAV  = 1;

endpackage

// File: rtl/sm_sign_ctrl.sv
module sm_sign_ctrl
   import sm_addsub_pkg::*;
(
   input  logic      a_sign,
   input  logic      b_sign,
   input  logic      op_sub,
   output logic      b_eff,
   output mag_path_e path
);

   always_comb begin
      b_eff = b_sign ^ op_sub;
      path  = (a_sign == b_eff) ? PATH_SUM : PATH_DIFF;
   end

endmodule

// File: rtl/sm_mag_adder.sv
module sm_mag_adder
   import sm_addsub_pkg::*;
#(
   parameter int W     = 8,
   parameter int STYLE = ADD_RIPPLE
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         invert,
   output logic [W-1:0] sum,
   output logic         cout
);

   localparam int CW = W + 1;

   logic [W-1:0] b_x;

   // Complementer: one XOR per bit under the mode control
   for (genvar i = 0; i < W; i++) begin : g_cmp
      assign b_x[i] = b[i] ^ invert;
   end

   if (STYLE == ADD_RIPPLE) begin : g_ripple
      logic [CW-1:0] c;
      assign c[0] = invert;
      for (genvar i = 0; i < W; i++) begin : g_fa
         assign sum[i]  = a[i] ^ b_x[i] ^ c[i];
         assign c[i+1]  = (a[i] & b_x[i]) | (c[i] & (a[i] ^ b_x[i]));
      end
      assign cout = c[W];
   end else if (STYLE == ADD_BEHAV) begin : g_behav
      logic [CW-1:0] full;
      assign full = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, invert};
      assign sum  = full[W-1:0];
      assign cout = full[W];
   end else begin : g_bad
      initial $error("sm_mag_adder: unsupported STYLE %0d", STYLE);
      assign sum  = '0;
      assign cout = 1'b0;
   end

endmodule

// File: rtl/sm_result_fix.sv
module sm_result_fix
   import sm_addsub_pkg::*;
#(
   parameter int W = 8
) (
   input  mag_path_e    path,
   input  logic         a_sign,
   input  logic [W-1:0] sum,
   input  logic         cout,
   output logic         res_sign,
   output logic [W-1:0] res_mag,
   output logic         ovf
);

   logic [W-1:0] neg_sum;
   logic         nonzero;

   always_comb begin
      neg_sum = ~sum + {{(W-1){1'b0}}, 1'b1};
      nonzero = |sum;
      if (path == PATH_SUM) begin
         res_mag  = sum;
         res_sign = a_sign;
         ovf      = cout;
      end else if (cout) begin
         // A >= B: the difference is already in true form
         res_mag  = sum;
         res_sign = a_sign & nonzero;
         ovf      = 1'b0;
      end else begin
         // A < B: undo the complement and flip the sign
         res_mag  = neg_sum;
         res_sign = ~a_sign;
         ovf      = 1'b0;
      end
   end

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
   import sm_addsub_pkg::*;
#(
   parameter int W         = 8,
   parameter int ADD_STYLE = ADD_RIPPLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic         a_sign,
   input  logic [W-1:0] a_mag,
   input  logic         b_sign,
   input  logic [W-1:0] b_mag,
   input  logic         op_sub,
   output logic         out_vld,
   output logic         res_sign,
   output logic [W-1:0] res_mag,
   output logic         ovf
);

   if (W < 1) begin : g_chk_w
      initial $error("sm_addsub: W must be at least 1");
   end
   if (ADD_STYLE != ADD_RIPPLE && ADD_STYLE != ADD_BEHAV) begin : g_chk_s
      initial $error("sm_addsub: bad ADD_STYLE");
   end

   mag_path_e    path;
   logic         b_eff;
   logic [W-1:0] sum;
   logic         cout;
   logic         n_sign;
   logic [W-1:0] n_mag;
   logic         n_ovf;

   sm_sign_ctrl u_sign (
      .a_sign (a_sign),
      .b_sign (b_sign),
      .op_sub (op_sub),
      .b_eff  (b_eff),
      .path   (path)
   );

   sm_mag_adder #(.W(W), .STYLE(ADD_STYLE)) u_add (
      .a      (a_mag),
      .b      (b_mag),
      .invert (path == PATH_DIFF),
      .sum    (sum),
      .cout   (cout)
   );

   sm_result_fix #(.W(W)) u_fix (
      .path     (path),
      .a_sign   (a_sign),
      .sum      (sum),
      .cout     (cout),
      .res_sign (n_sign),
      .res_mag  (n_mag),
      .ovf      (n_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         res_sign <= 1'b0;
         res_mag  <= '0;
         ovf      <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            res_sign <= n_sign;
            res_mag  <= n_mag;
            ovf      <= n_ovf;
         end
      end
   end

endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_vld,
   input logic         a_sign,
   input logic [W-1:0] a_mag,
   input logic         b_sign,
   input logic [W-1:0] b_mag,
   input logic         op_sub,
   input logic         out_vld,
   input logic         res_sign,
   input logic [W-1:0] res_mag,
   input logic         ovf
);

   logic armed;
   logic differ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign differ = a_sign != (b_sign ^ op_sub);

   AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_vld == $past(in_vld)));                                   // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !in_vld) |=> ($stable(res_mag) && $stable(res_sign) && $stable(ovf) && !out_vld)); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && differ) |=> !ovf);                                            // R4

   AST_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !differ) |=> (res_sign == $past(a_sign)));                    // R2

   AST_A_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && differ && (a_mag > b_mag)) |=> (res_sign == $past(a_sign)));  // R5

   AST_B_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && differ && (a_mag < b_mag)) |=> (res_sign != $past(a_sign)));  // R6

   AST_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && differ && (a_mag == b_mag)) |=> (!res_sign && res_mag == '0)); // R7

endmodule

bind sm_addsub sm_addsub_chk #(.W(W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .a_sign   (a_sign),
   .a_mag    (a_mag),
   .b_sign   (b_sign),
   .b_mag    (b_mag),
   .op_sub   (op_sub),
   .out_vld  (out_vld),
   .res_sign (res_sign),
   .res_mag  (res_mag),
   .ovf      (ovf)
);

// File: tb/sm_addsub_tb_top.sv
`timescale 1ns/1ps
module sm_addsub_tb_top;

   localparam int W   = 4;
   localparam int MAX = 1 << W;

   typedef struct {
      logic         sign;
      logic [W-1:0] mag;
      logic         ovf;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_vld = 1'b0;
   logic         a_sign = 1'b0;
   logic [W-1:0] a_mag = '0;
   logic         b_sign = 1'b0;
   logic [W-1:0] b_mag = '0;
   logic         op_sub = 1'b0;
   logic         out_vld;
   logic         res_sign;
   logic [W-1:0] res_mag;
   logic         ovf;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;
   bit   have_last = 0;
   exp_t last;
   exp_t q[$];

   always #2.5 clk = ~clk;

   sm_addsub #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
      .op_sub(op_sub), .out_vld(out_vld), .res_sign(res_sign),
      .res_mag(res_mag), .ovf(ovf)
   );

   function automatic void check(string req, logic s, logic [W-1:0] m, logic o,
                                 logic es, logic [W-1:0] em, logic eo);
      n_chk++;
      if (s !== es || m !== em || o !== eo) begin
         n_bad++;
         $display("FAIL %s: got sign=%0b mag=%0d ovf=%0b, expected sign=%0b mag=%0d ovf=%0b",
                  req, s, m, o, es, em, eo);
      end
   endfunction

   // Driver: integer reference model, pushes the expected result
   task automatic drive(bit as, int am, bit bs, int bm, bit sub);
      int   va, vb, r, absr;
      exp_t e;
      @(negedge clk);
      a_sign = as; a_mag = am[W-1:0];
      b_sign = bs; b_mag = bm[W-1:0];
      op_sub = sub; in_vld = 1'b1;
      va = as ? -am : am;
      vb = bs ? -bm : bm;
      r  = sub ? va - vb : va + vb;
      absr = (r < 0) ? -r : r;
      if (as == (bs ^ sub)) begin
         e.sign = as;
         e.mag  = absr[W-1:0];
         e.ovf  = (absr >= MAX);
         e.req  = e.ovf ? "R3" : (sub ? "R1/R2" : "R2");
      end else begin
         e.sign = (r < 0);
         e.mag  = absr[W-1:0];
         e.ovf  = 1'b0;
         if (am > bm)       e.req = sub ? "R1/R5" : "R5 R4";
         else if (am < bm)  e.req = sub ? "R1/R6" : "R6 R4";
         else               e.req = "R7";
      end
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_vld = 1'b0;
      a_mag = ~a_mag; b_sign = ~b_sign; op_sub = ~op_sub;
   endtask

   // Monitor: samples at the falling edge, after the registered update
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_vld) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL R8: out_vld high with no pending item, got 1 expected 0");
            end else begin
               e = q.pop_front();
               check(e.req, res_sign, res_mag, ovf, e.sign, e.mag, e.ovf);
               last = e;
               have_last = 1;
            end
         end else if (have_last) begin
            check("R9", res_sign, res_mag, ovf, last.sign, last.mag, last.ovf);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset values
      check("R8", res_sign, res_mag, ovf, 1'b0, '0, 1'b0);
      n_chk++;
      if (out_vld !== 1'b0) begin
         n_bad++;
         $display("FAIL R8: out_vld got %0b expected 0", out_vld);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // Directed corners
      drive(1, 0, 1, 0, 0);                   // R2 negative zero
      drive(0, MAX-1, 0, 1, 0);               // R3 wrap to 0
      idle(); idle();                         // R9 hold
      drive(1, 5, 1, 5, 1);                   // R7 via subtract
      drive(0, 3, 1, 9, 0);                   // R6
      idle();
      // Exhaustive sweep
      for (int sub = 0; sub < 2; sub++)
         for (int as = 0; as < 2; as++)
            for (int bs = 0; bs < 2; bs++)
               for (int am = 0; am < MAX; am++) begin
                  for (int bm = 0; bm < MAX; bm++)
                     drive(as[0], am, bs[0], bm, sub[0]);
                  if (am % 5 == 0) idle();
               end
      idle(); idle(); idle();
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R8: %0d results never appeared, expected 0", q.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule